// File: doc/BRIEF.md
# Bit-Selected-Clear PWM Timer

A single-channel pulse-width modulator driven from a slow reference tick of about 32 kHz. An 8-bit counter advances once per tick. A 2-bit prescaler chooses which counter bit clears the counter. When the incremented count would set that bit, the counter returns to zero instead. This gives four fixed periods of 128, 64, 32 or 16 ticks. The output is high while the low-order part of the count that is in use lies below a 7-bit duty value.

Software reaches the block through a small synchronous register port. The port has an address, a write strobe, write data and combinational read data. It holds two byte-wide registers: one for control (enable and prescaler) and one for the duty value. Writes to either register act on the next clock edge. There is no shadowing, so a duty or prescaler change lands in the middle of a period. A prescaler change also leaves the counter where it was.

Top module: `pwm_bitclr_timer`

## Requirements
- R1: While `rst_n` is low, and right after it, both registers, the counter and `pwm_out` are zero, and reads of address 0x00 and 0x01 return 0.
- R2: The control register sits at address 0x00. Write-data bit 7 is the enable and bits [1:0] are the prescaler. A read returns those bits in the same positions, with bits [6:2] reading 0.
- R3: The duty register sits at address 0x01 and stores write-data bits [6:0]. A read returns them with bit 7 at 0. A write to any other address changes nothing, and a read of any other address returns 0.
- R4: While enabled, the counter advances by one on each clock with `tick` high and holds on clocks with `tick` low.
- R5: With prescaler p, a count whose increment would set bit 7−p clears to 0 instead. This gives output periods of 128, 64, 32 and 16 ticks for p = 0, 1, 2, 3.
- R6: After every clock edge, `pwm_out` is 1 exactly when the enable is set and the count masked to bits [6−p:0] is strictly below the duty value. The output has no added cycle of lag.
- R7: A duty value of 0 gives a constant low output. A duty value at or above the period length gives a constant high output. Duty 127 with p = 0 drops low for one tick per period.
- R8: The clock edge that stores enable = 0 drives `pwm_out` low. The counter reads 0 from the following edge on and stays there while disabled, so re-enabling starts a fresh period.
- R9: A prescaler write does not clear the counter. The next tick applies the clear bit of the new prescaler to the count that is already there.
- R10: A duty write changes `pwm_out` on the edge that stores it, in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock pulse at the reference rate that advances the counter |
| reg_addr | input | 8 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The checker watches these on every cycle:
- the counter stays at zero while disabled, and the output is low in that state;
- the counter holds without a tick and otherwise steps by one or clears;
- with a stable prescaler, the count stays inside its period;
- duty 0 forces the output low and an oversized duty forces it high;
- the unused control bits read as zero.

Other behaviour depends on the history of register writes, and only the bench's scenarios can show it. This covers the exact period for each prescaler, the high time for a given duty, the carried-over count after a prescaler switch, and the mid-period response to a duty write. The bench follows each of these with a behavioural model, cycle by cycle.

// File: rtl/pwm_bitclr_pkg.sv
package pwm_bitclr_pkg;
  localparam int unsigned CNT_W_DEF     = 8;
  localparam int unsigned PSC_W_DEF     = 2;
  localparam int unsigned DATA_W_DEF    = 8;
  localparam int unsigned ADDR_W_DEF    = 8;
  localparam int unsigned EN_BIT_DEF    = 7;
  localparam int unsigned ADDR_CTRL_DEF = 0;
  localparam int unsigned ADDR_DUTY_DEF = 1;
endpackage

// File: rtl/pwm_bitclr_regs.sv
module pwm_bitclr_regs #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PSC_W     = 2,
  parameter int unsigned DUTY_W    = 7,
  parameter int unsigned EN_BIT    = 7,
  parameter int unsigned ADDR_CTRL = 0,
  parameter int unsigned ADDR_DUTY = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              en_q,
  output logic [PSC_W-1:0]  psc_q,
  output logic [DUTY_W-1:0] duty_q,
  output logic              en_d,
  output logic [PSC_W-1:0]  psc_d,
  output logic [DUTY_W-1:0] duty_d,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(ADDR_DUTY);

  logic ctrl_ce;
  logic duty_ce;

  // write decode and next-state values
  always_comb begin
    ctrl_ce = we && (addr == A_CTRL);
    duty_ce = we && (addr == A_DUTY);
    en_d    = ctrl_ce ? wdata[EN_BIT]      : en_q;
    psc_d   = ctrl_ce ? wdata[PSC_W-1:0]   : psc_q;
    duty_d  = duty_ce ? wdata[DUTY_W-1:0]  : duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      psc_q <= '0;
    end else if (ctrl_ce) begin
      en_q  <= en_d;
      psc_q <= psc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
    end else if (duty_ce) begin
      duty_q <= duty_d;
    end
  end

  // read mux: unused bits return zero
  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) begin
      rdata[EN_BIT]      = en_q;
      rdata[PSC_W-1:0]   = psc_q;
    end else if (addr == A_DUTY) begin
      rdata[DUTY_W-1:0]  = duty_q;
    end
  end
endmodule

// File: rtl/pwm_bitclr_timebase.sv
module pwm_bitclr_timebase #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);
  localparam int unsigned NUM_PSC = 1 << PSC_W;

  logic [CNT_W-1:0]   inc;
  logic [NUM_PSC-1:0] clr_hit;
  logic               cnt_ce;

  assign inc = cnt_q + CNT_W'(1);

  // one clear tap per prescaler setting: bit CNT_W-1-g of the increment
  for (genvar g = 0; g < NUM_PSC; g++) begin : g_tap
    assign clr_hit[g] = inc[CNT_W-1-g];
  end

  always_comb begin
    cnt_ce = !en || tick;
    if (!en) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = clr_hit[psc] ? '0 : inc;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pwm_bitclr_compare.sv
module pwm_bitclr_compare #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned PSC_W  = 2,
  parameter int unsigned DUTY_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_d,
  input  logic              en_d,
  input  logic [PSC_W-1:0]  psc_d,
  input  logic [DUTY_W-1:0] duty_d,
  output logic              pwm_q
);
  localparam int unsigned NUM_PSC = 1 << PSC_W;

  logic [CNT_W-1:0] masked [NUM_PSC];
  logic [CNT_W-1:0] in_period;
  logic [CNT_W-1:0] duty_ext;
  logic             pwm_d;

  // keep bits [CNT_W-2-g:0] for prescaler g
  for (genvar g = 0; g < NUM_PSC; g++) begin : g_mask
    localparam logic [CNT_W-1:0] MASK = {CNT_W{1'b1}} >> (g + 1);
    assign masked[g] = cnt_d & MASK;
  end

  always_comb begin
    in_period = masked[psc_d];
    duty_ext  = {{(CNT_W-DUTY_W){1'b0}}, duty_d};
    pwm_d     = en_d && (in_period < duty_ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= pwm_d;
    end
  end
endmodule

// File: rtl/pwm_bitclr_timer.sv
module pwm_bitclr_timer
  import pwm_bitclr_pkg::*;
#(
  parameter int unsigned CNT_W     = CNT_W_DEF,
  parameter int unsigned PSC_W     = PSC_W_DEF,
  parameter int unsigned DATA_W    = DATA_W_DEF,
  parameter int unsigned ADDR_W    = ADDR_W_DEF,
  parameter int unsigned EN_BIT    = EN_BIT_DEF,
  parameter int unsigned ADDR_CTRL = ADDR_CTRL_DEF,
  parameter int unsigned ADDR_DUTY = ADDR_DUTY_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out
);
  localparam int unsigned DUTY_W = CNT_W - 1;

  logic              en_q, en_d;
  logic [PSC_W-1:0]  psc_q, psc_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  pwm_bitclr_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PSC_W(PSC_W), .DUTY_W(DUTY_W),
    .EN_BIT(EN_BIT), .ADDR_CTRL(ADDR_CTRL), .ADDR_DUTY(ADDR_DUTY)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .en_q(en_q), .psc_q(psc_q), .duty_q(duty_q),
    .en_d(en_d), .psc_d(psc_d), .duty_d(duty_d),
    .rdata(reg_rdata)
  );

  pwm_bitclr_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_timebase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_q), .psc(psc_q),
    .cnt_q(cnt_q), .cnt_d(cnt_d)
  );

  pwm_bitclr_compare #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DUTY_W(DUTY_W)) u_compare (
    .clk(clk), .rst_n(rst_n), .cnt_d(cnt_d), .en_d(en_d), .psc_d(psc_d),
    .duty_d(duty_d), .pwm_q(pwm_out)
  );
endmodule

// File: rtl/pwm_bitclr_checker.sv
module pwm_bitclr_checker #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned PSC_W  = 2,
  parameter int unsigned DUTY_W = 7,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned EN_BIT = 7,
  parameter int unsigned ADDR_CTRL = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              en,
  input logic [PSC_W-1:0]  psc,
  input logic [DUTY_W-1:0] duty,
  input logic [CNT_W-1:0]  cnt,
  input logic              pwm_out,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata
);
  int lim;
  assign lim = 1 << (CNT_W - 1 - int'(psc));

  p_off_cnt_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (cnt == '0));

  p_off_out_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);

  p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt));

  p_step_or_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick) |=> ((cnt == '0) || (cnt == $past(cnt) + CNT_W'(1))));

  p_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $stable(psc) && (int'($past(cnt)) < lim)) |-> (int'(cnt) < lim));

  p_duty_zero_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |-> !pwm_out);

  p_duty_over_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (int'(duty) >= lim)) |-> pwm_out);

  p_ctrl_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(ADDR_CTRL)) |-> (reg_rdata[EN_BIT-1:PSC_W] == '0));
endmodule

bind pwm_bitclr_timer pwm_bitclr_checker #(
  .CNT_W(CNT_W), .PSC_W(PSC_W), .DUTY_W(DUTY_W), .ADDR_W(ADDR_W),
  .DATA_W(DATA_W), .EN_BIT(EN_BIT), .ADDR_CTRL(ADDR_CTRL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_q), .psc(psc_q), .duty(duty_q),
  .cnt(cnt_q), .pwm_out(pwm_out), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/pwm_bitclr_timer_bench.sv
`timescale 1ns/1ps
module pwm_bitclr_timer_bench;
  localparam int TICK_DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       pwm_out;

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit track = 1'b0;

  // behavioural model state
  int m_en = 0, m_psc = 0, m_duty = 0, m_cnt = 0;

  always #2 clk = ~clk;

  pwm_bitclr_timer u_pwm_bitclr_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int period_of(input int p);
    return 1 << (7 - p);
  endfunction

  function automatic int model_out();
    return (m_en != 0 && (m_cnt % period_of(m_psc)) < m_duty) ? 1 : 0;
  endfunction

  function automatic int model_read(input int a);
    if (a == 0) return (m_en << 7) | m_psc;
    if (a == 1) return m_duty;
    return 0;
  endfunction

  // reference model: counter uses the register values held before the edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_psc = 0; m_duty = 0; m_cnt = 0;
    end else begin
      if (m_en == 0) m_cnt = 0;
      else if (tick) begin
        int n;
        n = m_cnt + 1;
        m_cnt = ((n >> (7 - m_psc)) & 1) ? 0 : n;
      end
      if (reg_we && reg_addr == 8'h00) begin
        m_en = reg_wdata[7]; m_psc = reg_wdata[1:0];
      end
      if (reg_we && reg_addr == 8'h01) m_duty = reg_wdata[6:0];
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && track) begin
      chk({phase, " out"}, pwm_out, model_out());
      chk({phase, " rdata"}, reg_rdata, model_read(reg_addr));
    end
  end

  // reference tick
  initial begin
    int d = 0;
    forever begin
      @(posedge clk); #1;
      tick = (d == TICK_DIV - 1);
      d = (d + 1) % TICK_DIV;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = v; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input int exp);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    chk(req, reg_rdata, exp);
  endtask

  task automatic wait_rise();
    logic prev;
    @(negedge clk); prev = pwm_out;
    forever begin
      @(negedge clk);
      if (pwm_out && !prev) break;
      prev = pwm_out;
    end
  endtask

  task automatic measure(output int clocks, output int high);
    logic prev;
    wait_rise();
    clocks = 0; high = 1; prev = 1'b1;
    forever begin
      @(negedge clk);
      clocks++;
      if (pwm_out && !prev) break;
      if (pwm_out) high++;
      prev = pwm_out;
    end
  endtask

  task automatic const_level(input string req, input int cycles, input int lvl);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwm_out != lvl) bad++;
    end
    chk(req, bad, 0);
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int clocks, high;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 out in reset", pwm_out, 0);
    chk("R1 ctrl read in reset", reg_rdata, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out after reset", pwm_out, 0);
    rd("R1 duty read after reset", 8'h01, 0);
    track = 1'b1;

    // R2, R3: register map
    phase = "R2";
    wr(8'h00, 8'hFF);
    rd("R2 ctrl readback pads zero", 8'h00, 8'h83);
    phase = "R3";
    wr(8'h01, 8'hFF);
    rd("R3 duty readback bit7 zero", 8'h01, 8'h7F);
    wr(8'h05, 8'h00);
    rd("R3 stray write leaves ctrl", 8'h00, 8'h83);
    rd("R3 stray write leaves duty", 8'h01, 8'h7F);
    rd("R3 unmapped read zero", 8'h05, 0);

    // R8: disable holds low, re-enable starts fresh period
    phase = "R8";
    wr(8'h00, 8'h03);
    const_level("R8 disabled output low", 60, 0);
    wr(8'h01, 8'h01);
    @(posedge clk); #1;
    reg_addr = 8'h00; reg_wdata = 8'h83; reg_we = 1'b1;
    @(negedge clk);
    chk("R8 before enable lands", pwm_out, 0);
    @(posedge clk); #1; reg_we = 1'b0;
    @(negedge clk);
    chk("R8 fresh period high at enable", pwm_out, 1);

    // R5: period per prescaler, R4 tick pacing folded in
    phase = "R5";
    for (int p = 0; p < 4; p++) begin
      wr(8'h00, 8'h80 | p[7:0]);
      measure(clocks, high);
      measure(clocks, high);
      chk($sformatf("R5 R4 period p=%0d", p), clocks, period_of(p) * TICK_DIV);
    end

    // R6: high time
    phase = "R6";
    wr(8'h00, 8'h82);
    wr(8'h01, 8'd5);
    measure(clocks, high);
    measure(clocks, high);
    chk("R6 high time duty5 p2", high, 5 * TICK_DIV);

    // R7: duty extremes
    phase = "R7";
    wr(8'h01, 8'd0);
    const_level("R7 duty0 low", 300, 0);
    wr(8'h00, 8'h81);
    wr(8'h01, 8'd64);
    const_level("R7 duty64 p1 high", 300, 1);
    wr(8'h00, 8'h80);
    wr(8'h01, 8'd127);
    wait_rise();
    measure(clocks, high);
    chk("R7 duty127 p0 low one tick", clocks - high, TICK_DIV);

    // R10: mid-period duty change
    phase = "R10";
    wr(8'h01, 8'd100);
    wait_rise();
    repeat (20 * TICK_DIV) @(negedge clk);
    chk("R10 high before change", pwm_out, 1);
    @(posedge clk); #1;
    reg_addr = 8'h01; reg_wdata = 8'd10; reg_we = 1'b1;
    @(posedge clk); #1; reg_we = 1'b0;
    @(negedge clk);
    chk("R10 low right after duty write", pwm_out, 0);
    wr(8'h01, 8'd100);
    @(negedge clk);
    chk("R10 high again after duty write", pwm_out, 1);

    // R9: prescaler switches mid-period, followed by the model
    phase = "R9";
    wr(8'h01, 8'd40);
    for (int k = 0; k < 24; k++) begin
      repeat (17 + 13 * k) @(negedge clk);
      wr(8'h00, 8'h80 | ((k * 3) % 4));
    end
    wr(8'h00, 8'h80);
    repeat (90 * TICK_DIV) @(negedge clk);
    wr(8'h00, 8'h83);
    repeat (2 * TICK_DIV) @(negedge clk);
    rd("R9 readback after switch", 8'h00, 8'h83);
    repeat (200) @(negedge clk);

    track = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule